// File: doc/BRIEF.md
# Interrupt Acceptance Sequencer

This block sits beside the execution core of an 8-bit processor with a 16-bit address space and handles the response to interrupts. It watches a non-maskable request line and a maskable request line. When one is accepted, it saves the current program counter on the descending stack, one byte per cycle through a byte-wide write port. It then gives the core the restart address, the lowered stack pointer and the number of clock cycles the response costs.

The block also holds the interrupt state that the core's instructions change: a main enable flag, a shadow enable flag and a two-bit interrupt mode register. The core strobes disable, enable and set-mode commands into the block. The non-maskable response copies the main flag into the shadow flag and then clears the main flag, so the prior enable state can be restored later. Maskable requests are served only in mode 1, through the fixed restart address, and leave both flags unchanged.

Top module: `irq_accept_seq`

## Requirements
- R1: After synchronous reset both enable flags are 0, the mode is 0, `done` and `mem_we` are 0, and `pc_out`, `sp_out` and `cost` are 0.
- R2: An accepted non-maskable request produces `pc_out` = 0x0066 and `cost` = 17 in the cycle `done` is high.
- R3: On non-maskable acceptance the main flag becomes 0 and the shadow flag takes the value the main flag had just before. Both are visible by the cycle `done` is high.
- R4: The return address is pushed high byte first, to address SP-1, and the low byte is pushed in the next cycle to SP-2. `sp_out` becomes SP-2. All stack addresses wrap modulo 2^16. SP and PC are sampled in the acceptance cycle.
- R5: An accepted maskable request produces `pc_out` = 0x0038 and `cost` = 11. It uses the same push as R4 and leaves both enable flags unchanged.
- R6: A maskable request is ignored while the main flag is 0 or the mode is not 1. In that case no write, no `done` and no change of `pc_out` occur.
- R7: When both request kinds are accepted candidates in the same cycle, the non-maskable one is served.
- R8: The non-maskable line is edge-triggered. A line held high yields exactly one response. A rising edge that arrives while a response is running is kept and served after that response.
- R9: The disable command clears both enable flags and the enable command sets both. They take effect one cycle after the strobe. Disable wins if both are strobed together.
- R10: The set-mode command loads `mode` from `im_val` one cycle after the strobe and leaves both enable flags unchanged.
- R11: A request sampled high at clock edge N is accepted at that edge. The two writes occur in the cycles after edges N and N+1, and `done` is high for one cycle after edge N+2. `busy` is high from acceptance through `done`, and no new request is accepted while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_in | input | 16 | Current program counter from the core |
| sp_in | input | 16 | Current stack pointer from the core |
| nmi_req | input | 1 | Non-maskable request line (rising edge counts) |
| int_req | input | 1 | Maskable request line (level) |
| cmd_di | input | 1 | Disable-interrupts strobe |
| cmd_ei | input | 1 | Enable-interrupts strobe |
| cmd_im | input | 1 | Set-mode strobe |
| im_val | input | 2 | Mode value loaded by `cmd_im` |
| busy | output | 1 | A response is in progress |
| mem_we | output | 1 | Stack byte write strobe |
| mem_addr | output | 16 | Stack write address |
| mem_wdata | output | 8 | Stack write data |
| done | output | 1 | One-cycle pulse when PC, SP and cost are updated |
| pc_out | output | 16 | Restart address of the last response |
| sp_out | output | 16 | Stack pointer after the last response |
| cost | output | 5 | Cycle cost of the last response |
| iff1 | output | 1 | Main interrupt enable flag |
| iff2 | output | 1 | Shadow interrupt enable flag |
| mode | output | 2 | Interrupt mode register |

## Verification
A wrong sequencer state shows on the write port within a cycle of acceptance: a missing, doubled or reordered byte, or an address step other than minus one. The `done` pulse and `pc_out` lag the first write by exactly two cycles. A wrong flag update (shadow copy, disable, enable) is visible on `iff1`/`iff2` one cycle after the strobe or acceptance. A lost or duplicated non-maskable edge shows as a missing or extra burst of writes within three cycles of the sequencer returning to idle.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
    localparam int COST_W = 5;
    localparam int MODE_W = 2;

    localparam logic [ADDR_W-1:0] NMI_VECTOR  = 16'h0066;
    localparam logic [ADDR_W-1:0] MASK_VECTOR = 16'h0038;
    localparam logic [COST_W-1:0] NMI_CYCLES  = 5'd17;
    localparam logic [COST_W-1:0] MASK_CYCLES = 5'd11;
    localparam logic [MODE_W-1:0] MASK_MODE   = 2'd1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_NMI,
        SRC_MASK
    } irq_src_e;

    typedef struct packed {
        logic [ADDR_W-1:0] vector;
        logic [COST_W-1:0] cycles;
    } resp_t;

    function automatic resp_t resp_for(irq_src_e src);
        resp_t r;
        if (src == SRC_NMI) begin
            r.vector = NMI_VECTOR;
            r.cycles = NMI_CYCLES;
        end else begin
            r.vector = MASK_VECTOR;
            r.cycles = MASK_CYCLES;
        end
        return r;
    endfunction

    function automatic logic [ADDR_W-1:0] stack_slot(logic [ADDR_W-1:0] sp,
                                                     logic [ADDR_W-1:0] depth);
        return ADDR_W'(sp - depth);
    endfunction

endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     idle,
    input  logic     nmi_req,
    input  logic     int_req,
    input  logic     int_allow,
    output irq_src_e pick
);
    logic nmi_prev;
    logic nmi_pend;
    logic nmi_edge;
    logic nmi_avail;

    assign nmi_edge  = nmi_req & ~nmi_prev;
    assign nmi_avail = nmi_edge | nmi_pend;

    always_comb begin
        pick = SRC_NONE;
        if (idle) begin
            if (nmi_avail)
                pick = SRC_NMI;
            else if (int_req && int_allow)
                pick = SRC_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_prev <= 1'b0;
            nmi_pend <= 1'b0;
        end else begin
            nmi_prev <= nmi_req;
            nmi_pend <= nmi_avail & (pick != SRC_NMI);
        end
    end
endmodule

// File: rtl/irq_enable_regs.sv
module irq_enable_regs
    import irq_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  irq_src_e          pick,
    input  logic              cmd_di,
    input  logic              cmd_ei,
    input  logic              cmd_im,
    input  logic [MODE_W-1:0] im_val,
    output logic              iff1,
    output logic              iff2,
    output logic [MODE_W-1:0] mode
);
    always_ff @(posedge clk) begin
        if (rst) begin
            iff1 <= 1'b0;
            iff2 <= 1'b0;
            mode <= '0;
        end else begin
            if (cmd_im)
                mode <= im_val;
            if (pick == SRC_NMI) begin
                iff2 <= iff1;
                iff1 <= 1'b0;
            end else if (cmd_di) begin
                iff1 <= 1'b0;
                iff2 <= 1'b0;
            end else if (cmd_ei) begin
                iff1 <= 1'b1;
                iff2 <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_push_seq.sv
module irq_push_seq
    import irq_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  irq_src_e          pick,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [ADDR_W-1:0] sp_in,
    output logic              idle,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              done,
    output logic [ADDR_W-1:0] pc_out,
    output logic [ADDR_W-1:0] sp_out,
    output logic [COST_W-1:0] cost
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

    seq_state_e        state;
    logic [ADDR_W-1:0] ret_pc;
    logic [ADDR_W-1:0] sp_base;
    resp_t             held;

    assign idle = (state == ST_IDLE);
    assign done = (state == ST_DONE);

    always_comb begin
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            ST_PUSH_HI: begin
                mem_we    = 1'b1;
                mem_addr  = stack_slot(sp_base, ONE);
                mem_wdata = ret_pc[ADDR_W-1 -: BYTE_W];
            end
            ST_PUSH_LO: begin
                mem_we    = 1'b1;
                mem_addr  = stack_slot(sp_base, TWO);
                mem_wdata = ret_pc[BYTE_W-1:0];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            ret_pc  <= '0;
            sp_base <= '0;
            held    <= '0;
            pc_out  <= '0;
            sp_out  <= '0;
            cost    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (pick != SRC_NONE) begin
                        ret_pc  <= pc_in;
                        sp_base <= sp_in;
                        held    <= resp_for(pick);
                        state   <= ST_PUSH_HI;
                    end
                end
                ST_PUSH_HI: state <= ST_PUSH_LO;
                ST_PUSH_LO: begin
                    pc_out <= held.vector;
                    sp_out <= stack_slot(sp_base, TWO);
                    cost   <= held.cycles;
                    state  <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/irq_accept_seq.sv
module irq_accept_seq
    import irq_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] pc_in,
    input  logic [15:0] sp_in,
    input  logic        nmi_req,
    input  logic        int_req,
    input  logic        cmd_di,
    input  logic        cmd_ei,
    input  logic        cmd_im,
    input  logic [1:0]  im_val,
    output logic        busy,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    output logic        done,
    output logic [15:0] pc_out,
    output logic [15:0] sp_out,
    output logic [4:0]  cost,
    output logic        iff1,
    output logic        iff2,
    output logic [1:0]  mode
);
    irq_src_e pick;
    logic     idle;
    logic     int_allow;
    logic     pick_nmi;

    assign int_allow = iff1 && (mode == MASK_MODE);
    assign busy      = ~idle;
    assign pick_nmi  = (pick == SRC_NMI);

    irq_arbiter u_arb (
        .clk       (clk),
        .rst       (rst),
        .idle      (idle),
        .nmi_req   (nmi_req),
        .int_req   (int_req),
        .int_allow (int_allow),
        .pick      (pick)
    );

    irq_enable_regs u_en (
        .clk    (clk),
        .rst    (rst),
        .pick   (pick),
        .cmd_di (cmd_di),
        .cmd_ei (cmd_ei),
        .cmd_im (cmd_im),
        .im_val (im_val),
        .iff1   (iff1),
        .iff2   (iff2),
        .mode   (mode)
    );

    irq_push_seq u_push (
        .clk       (clk),
        .rst       (rst),
        .pick      (pick),
        .pc_in     (pc_in),
        .sp_in     (sp_in),
        .idle      (idle),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .done      (done),
        .pc_out    (pc_out),
        .sp_out    (sp_out),
        .cost      (cost)
    );
endmodule

// File: rtl/irq_accept_seq_chk.sv
module irq_accept_seq_chk
    import irq_seq_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        mem_we,
    input logic [15:0] mem_addr,
    input logic        done,
    input logic [15:0] pc_out,
    input logic [4:0]  cost,
    input logic        iff1,
    input logic        iff2,
    input logic        cmd_di,
    input logic        pick_nmi
);
    assert_push_step_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !$past(mem_we)) |=> (mem_we && mem_addr == 16'($past(mem_addr) - 16'd1)));

    assert_done_after_push_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(mem_we) && !mem_we));

    assert_nmi_cost_R2: assert property (@(posedge clk) disable iff (rst)
        (done && pc_out == NMI_VECTOR) |-> (cost == NMI_CYCLES));

    assert_mask_cost_R5: assert property (@(posedge clk) disable iff (rst)
        (done && pc_out == MASK_VECTOR) |-> (cost == MASK_CYCLES));

    assert_nmi_shadow_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(pick_nmi) && !$past(rst)) |-> (!iff1 && iff2 == $past(iff1)));

    assert_disable_both_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(cmd_di) && !$past(pick_nmi) && !$past(rst)) |-> (!iff1 && !iff2));

    assert_write_done_excl_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_we, done}));
endmodule

bind irq_accept_seq irq_accept_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .done     (done),
    .pc_out   (pc_out),
    .cost     (cost),
    .iff1     (iff1),
    .iff2     (iff2),
    .cmd_di   (cmd_di),
    .pick_nmi (pick_nmi)
);

// File: tb/sim_irq_accept_seq.sv
`timescale 1ns/1ps
module sim_irq_accept_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] pc_in, sp_in;
    logic        nmi_req, int_req, cmd_di, cmd_ei, cmd_im;
    logic [1:0]  im_val;
    logic        busy, mem_we, done, iff1, iff2;
    logic [15:0] mem_addr, pc_out, sp_out;
    logic [7:0]  mem_wdata;
    logic [4:0]  cost;
    logic [1:0]  mode;

    int total = 0;
    int bad   = 0;
    bit m_iff1, m_iff2;
    bit [1:0] m_mode;
    logic [15:0] last_pc;

    always #2 clk = ~clk;

    irq_accept_seq u0 (
        .clk(clk), .rst(rst), .pc_in(pc_in), .sp_in(sp_in),
        .nmi_req(nmi_req), .int_req(int_req), .cmd_di(cmd_di), .cmd_ei(cmd_ei),
        .cmd_im(cmd_im), .im_val(im_val), .busy(busy), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done), .pc_out(pc_out),
        .sp_out(sp_out), .cost(cost), .iff1(iff1), .iff2(iff2), .mode(mode)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_vec(bit nmi);
        return nmi ? 16'h0066 : 16'h0038;
    endfunction

    function automatic logic [4:0] exp_cost(bit nmi);
        return nmi ? 5'd17 : 5'd11;
    endfunction

    task automatic do_cmd(int kind, logic [1:0] v);
        @(negedge clk);
        cmd_di = (kind == 0); cmd_ei = (kind == 1); cmd_im = (kind == 2); im_val = v;
        @(negedge clk);
        cmd_di = 0; cmd_ei = 0; cmd_im = 0;
        if (kind == 0) begin m_iff1 = 0; m_iff2 = 0; end
        if (kind == 1) begin m_iff1 = 1; m_iff2 = 1; end
        if (kind == 2) m_mode = v;
        check(kind == 2 ? "R10 mode" : "R9 iff1", kind == 2 ? 32'(mode) : 32'(iff1),
              kind == 2 ? 32'(m_mode) : 32'(m_iff1));
        check("R10/R9 iff2", 32'(iff2), 32'(m_iff2));
    endtask

    // Checks the push burst starting at the current negedge (first write visible).
    task automatic check_burst(bit nmi, logic [15:0] pc, logic [15:0] sp);
        check("R4 we hi", 32'(mem_we), 1);
        check("R4 addr hi", 32'(mem_addr), 32'(16'(sp - 16'd1)));
        check("R4 data hi", 32'(mem_wdata), 32'(pc[15:8]));
        @(negedge clk);
        check("R4 we lo", 32'(mem_we), 1);
        check("R4 addr lo", 32'(mem_addr), 32'(16'(sp - 16'd2)));
        check("R4 data lo", 32'(mem_wdata), 32'(pc[7:0]));
        @(negedge clk);
        check("R11 done", 32'(done), 1);
        check(nmi ? "R2 vector" : "R5 vector", 32'(pc_out), 32'(exp_vec(nmi)));
        check(nmi ? "R2 cost" : "R5 cost", 32'(cost), 32'(exp_cost(nmi)));
        check("R4 sp_out", 32'(sp_out), 32'(16'(sp - 16'd2)));
        if (nmi) begin m_iff2 = m_iff1; m_iff1 = 0; end
        check(nmi ? "R3 iff1" : "R5 iff1", 32'(iff1), 32'(m_iff1));
        check(nmi ? "R3 iff2" : "R5 iff2", 32'(iff2), 32'(m_iff2));
        last_pc = pc_out;
        @(negedge clk);
        check("R11 busy clear", 32'(busy), 0);
    endtask

    task automatic fire(bit nmi, bit intr, logic [15:0] pc, logic [15:0] sp);
        bit take_nmi, take_int;
        take_nmi = nmi;
        take_int = !nmi && intr && m_iff1 && (m_mode == 2'd1);
        @(negedge clk);
        pc_in = pc; sp_in = sp; nmi_req = nmi; int_req = intr;
        @(negedge clk);
        nmi_req = 0; int_req = 0; pc_in = 16'hDEAD; sp_in = 16'hBEEF;
        if (take_nmi || take_int) begin
            check("R11 busy", 32'(busy), 1);
            check_burst(take_nmi, pc, sp);
        end else begin
            for (int i = 0; i < 4; i++) begin
                check("R6 no write", 32'({mem_we, done}), 0);
                @(negedge clk);
            end
            check("R6 pc_out kept", 32'(pc_out), 32'(last_pc));
        end
    endtask

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] rpc, rsp;
        void'($urandom(32'd2417));
        rst = 1; pc_in = 0; sp_in = 0; nmi_req = 0; int_req = 0;
        cmd_di = 0; cmd_ei = 0; cmd_im = 0; im_val = 0;
        m_iff1 = 0; m_iff2 = 0; m_mode = 0; last_pc = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 iff1", 32'(iff1), 0);
        check("R1 iff2", 32'(iff2), 0);
        check("R1 mode", 32'(mode), 0);
        check("R1 outs", 32'({done, mem_we, cost}), 0);
        check("R1 pc/sp", {pc_out, sp_out}, 0);

        // NMI with flags set: shadow captures 1
        do_cmd(1, 0);
        fire(1, 0, 16'h1234, 16'h3FFF);
        // maskable ignored: main flag now clear
        do_cmd(2, 2'd1);
        fire(0, 1, 16'h4444, 16'h2000);
        // maskable accepted in mode 1
        do_cmd(1, 0);
        fire(0, 1, 16'h1234, 16'h3FFF);
        // ignored in mode 2 with flags set
        do_cmd(2, 2'd2);
        fire(0, 1, 16'h5555, 16'h3000);
        do_cmd(2, 2'd1);
        // priority R7
        fire(1, 1, 16'hA55A, 16'h8000);
        // stack wrap R4
        do_cmd(1, 0);
        fire(0, 1, 16'hC3E1, 16'h0001);
        fire(1, 0, 16'h0F0F, 16'h0000);
        // DI clears both R9
        do_cmd(1, 0);
        do_cmd(0, 0);

        // R8 held line yields one response
        @(negedge clk);
        pc_in = 16'h7777; sp_in = 16'h4000; nmi_req = 1;
        @(negedge clk);
        check_burst(1, 16'h7777, 16'h4000);
        for (int i = 0; i < 6; i++) begin
            check("R8 held no repeat", 32'(mem_we), 0);
            @(negedge clk);
        end
        nmi_req = 0;

        // R8 edge during busy is kept
        do_cmd(1, 0);
        @(negedge clk);
        pc_in = 16'h2468; sp_in = 16'h1000; int_req = 1;
        @(negedge clk);
        int_req = 0; nmi_req = 1; pc_in = 16'h9999; sp_in = 16'h5000;
        check_burst(0, 16'h2468, 16'h1000);
        begin
            int waited = 0;
            while (!mem_we && waited < 8) begin
                @(negedge clk);
                waited++;
            end
            check("R8 pending served", 32'(mem_we), 1);
            nmi_req = 0;
            check_burst(1, 16'h9999, 16'h5000);
        end

        // random mix
        for (int it = 0; it < 80; it++) begin
            int op;
            op = $urandom % 6;
            rpc = 16'($urandom);
            rsp = 16'($urandom);
            case (op)
                0: do_cmd(0, 0);
                1: do_cmd(1, 0);
                2: do_cmd(2, 2'($urandom));
                3: fire(1, 0, rpc, rsp);
                4: fire(0, 1, rpc, rsp);
                default: fire(1, 1, rpc, rsp);
            endcase
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule